// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is the master end of an open-drain, single-wire serial bus. A host issues one command at a time: a bus reset with presence detection, one written bit, one read bit, or a byte of either kind. The block turns each command into a pin waveform. Its output is a drive-low enable for an external open-drain pad with a pull-up. The line level returns through a two-flop synchronizer and is sampled at fixed points inside each slot.

Every phase length is a parameter counted in system clock ticks. There are two complete timing sets, standard and overdrive. The `overdrive` input selects between them and is latched when a command is accepted. When the command finishes, `done` pulses for one cycle. At that edge `presence` is updated (after a reset) or `rdata` is updated (after a read). A byte command runs eight slots. Bits are sent and assembled least significant first.

Top module: `swire_master`

## Requirements
- R1: A reset command (`cmd_op` = 0) drives the line low for exactly the selected reset-low tick count. It then releases the line for the selected release-window tick count. `busy` is high for the sum of these two counts.
- R2: `presence` is set to 1 if the synchronized line is low at the presence sample point of the release window, and to 0 otherwise. It changes only in the cycle in which `done` is high.
- R3: A write slot (`cmd_op` = 1) carrying a 1 drives the line low for exactly the write-1 low tick count.
- R4: A write slot carrying a 0 drives the line low for exactly the full slot tick count.
- R5: A read slot (`cmd_op` = 2) drives the line low for exactly the read-low tick count. It captures the synchronized line at the read sample point. A bit read returns the sampled level in `rdata[0]`, with bits 7..1 cleared. `rdata` changes only while `done` is high.
- R6: Within a byte command, consecutive slot starts are exactly slot plus recovery ticks apart. A bit or byte command keeps `busy` high for (number of slots) × (slot + recovery) ticks.
- R7: A byte write (`cmd_byte` = 1) sends `cmd_wdata` bit 0 first and bit 7 last.
- R8: A byte read places the bit from the first slot in `rdata[0]` and the bit from the eighth slot in `rdata[7]`.
- R9: A command is accepted only when `busy` is low and `cmd_op` is 0, 1 or 2. `busy` rises in the cycle after acceptance. A command presented while busy, or with `cmd_op` = 3, has no effect.
- R10: With `overdrive` high at acceptance, the command uses the overdrive tick counts for every phase.
- R11: After reset, `drive_low`, `busy`, `done`, `presence` and `rdata` are all zero. The line is never driven while `busy` is low.
- R12: `done` is a one-cycle pulse. In that cycle `busy` is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, sampled when not busy |
| cmd_op | input | 2 | 0 reset, 1 write, 2 read, 3 ignored |
| cmd_byte | input | 1 | 1: eight-slot byte command, 0: single slot |
| cmd_wdata | input | 8 | Write data; bit 0 used for single-bit write |
| overdrive | input | 1 | Speed select latched at accept: 1 overdrive |
| line_in | input | 1 | Raw bus level from the pad |
| drive_low | output | 1 | Open-drain enable: 1 pulls the line low |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| presence | output | 1 | Presence result of the last reset |
| rdata | output | 8 | Result of the last read command |

## Verification
The bench builds the block with short tick counts. Standard mode uses a 40-tick reset low, a 16-tick slot and 3-tick recovery. Overdrive uses a 20-tick reset low, an 8-tick slot and 2-tick recovery. These values put every phase, including full eight-slot byte commands in both speeds, within a few hundred cycles. The sample points are placed close to the two-flop synchronizer latency. This lets a behavioural slave model on the wire show whether the presence and read samples land in the right slot phase.

// File: rtl/swire_pkg.sv
package swire_pkg;

    localparam logic [1:0] OP_RESET = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_READ  = 2'd2;

    localparam int BYTE_BITS = 8;
    localparam int IDX_W     = $clog2(BYTE_BITS);

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RST_LOW = 3'd1,
        ST_RST_REL = 3'd2,
        ST_SLOT    = 3'd3,
        ST_REC     = 3'd4
    } swire_state_e;

endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
    parameter int STAGES = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[i] <= RESET_VAL;
                end else begin
                    if (i == 0) begin
                        chain_q[i] <= d_in;
                    end else begin
                        chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
                    end
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/swire_timing.sv
module swire_timing #(
    parameter int CNT_W          = 16,
    parameter int STD_RST_LOW    = 24000,
    parameter int STD_PRES_SMP   = 3500,
    parameter int STD_RST_REL    = 24000,
    parameter int STD_SLOT       = 3000,
    parameter int STD_W1_LOW     = 300,
    parameter int STD_RD_LOW     = 100,
    parameter int STD_RD_SMP     = 750,
    parameter int STD_REC        = 250,
    parameter int OD_RST_LOW     = 2400,
    parameter int OD_PRES_SMP    = 400,
    parameter int OD_RST_REL     = 2400,
    parameter int OD_SLOT        = 300,
    parameter int OD_W1_LOW      = 50,
    parameter int OD_RD_LOW      = 50,
    parameter int OD_RD_SMP      = 100,
    parameter int OD_REC         = 100
) (
    input  logic             od_sel,
    output logic [CNT_W-1:0] t_rst_low,
    output logic [CNT_W-1:0] t_pres_smp,
    output logic [CNT_W-1:0] t_rst_rel,
    output logic [CNT_W-1:0] t_slot,
    output logic [CNT_W-1:0] t_w1_low,
    output logic [CNT_W-1:0] t_rd_low,
    output logic [CNT_W-1:0] t_rd_smp,
    output logic [CNT_W-1:0] t_rec
);
    localparam logic [CNT_W-1:0] S_RL = CNT_W'(STD_RST_LOW);
    localparam logic [CNT_W-1:0] S_PS = CNT_W'(STD_PRES_SMP);
    localparam logic [CNT_W-1:0] S_RR = CNT_W'(STD_RST_REL);
    localparam logic [CNT_W-1:0] S_SL = CNT_W'(STD_SLOT);
    localparam logic [CNT_W-1:0] S_W1 = CNT_W'(STD_W1_LOW);
    localparam logic [CNT_W-1:0] S_RD = CNT_W'(STD_RD_LOW);
    localparam logic [CNT_W-1:0] S_RS = CNT_W'(STD_RD_SMP);
    localparam logic [CNT_W-1:0] S_RC = CNT_W'(STD_REC);
    localparam logic [CNT_W-1:0] O_RL = CNT_W'(OD_RST_LOW);
    localparam logic [CNT_W-1:0] O_PS = CNT_W'(OD_PRES_SMP);
    localparam logic [CNT_W-1:0] O_RR = CNT_W'(OD_RST_REL);
    localparam logic [CNT_W-1:0] O_SL = CNT_W'(OD_SLOT);
    localparam logic [CNT_W-1:0] O_W1 = CNT_W'(OD_W1_LOW);
    localparam logic [CNT_W-1:0] O_RD = CNT_W'(OD_RD_LOW);
    localparam logic [CNT_W-1:0] O_RS = CNT_W'(OD_RD_SMP);
    localparam logic [CNT_W-1:0] O_RC = CNT_W'(OD_REC);

    always_comb begin
        t_rst_low  = od_sel ? O_RL : S_RL;
        t_pres_smp = od_sel ? O_PS : S_PS;
        t_rst_rel  = od_sel ? O_RR : S_RR;
        t_slot     = od_sel ? O_SL : S_SL;
        t_w1_low   = od_sel ? O_W1 : S_W1;
        t_rd_low   = od_sel ? O_RD : S_RD;
        t_rd_smp   = od_sel ? O_RS : S_RS;
        t_rec      = od_sel ? O_RC : S_RC;
    end
endmodule

// File: rtl/swire_master.sv
module swire_master
    import swire_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int STD_RST_LOW    = 24000,
    parameter int STD_PRES_SMP   = 3500,
    parameter int STD_RST_REL    = 24000,
    parameter int STD_SLOT       = 3000,
    parameter int STD_W1_LOW     = 300,
    parameter int STD_RD_LOW     = 100,
    parameter int STD_RD_SMP     = 750,
    parameter int STD_REC        = 250,
    parameter int OD_RST_LOW     = 2400,
    parameter int OD_PRES_SMP    = 400,
    parameter int OD_RST_REL     = 2400,
    parameter int OD_SLOT        = 300,
    parameter int OD_W1_LOW      = 50,
    parameter int OD_RD_LOW      = 50,
    parameter int OD_RD_SMP      = 100,
    parameter int OD_REC         = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_byte,
    input  logic [7:0] cmd_wdata,
    input  logic       overdrive,
    input  logic       line_in,
    output logic       drive_low,
    output logic       busy,
    output logic       done,
    output logic       presence,
    output logic [7:0] rdata
);
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int MAX_STD = imax(imax(STD_RST_LOW, STD_RST_REL), imax(STD_SLOT, STD_REC));
    localparam int MAX_OD  = imax(imax(OD_RST_LOW, OD_RST_REL), imax(OD_SLOT, OD_REC));
    localparam int MAX_T   = imax(MAX_STD, MAX_OD);
    localparam int CNT_W   = $clog2(MAX_T + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_BITS - 1);

    typedef struct packed {
        swire_state_e           state;
        logic [CNT_W-1:0]       cnt;
        logic [IDX_W-1:0]       idx;
        logic                   od;
        logic [1:0]             op;
        logic                   byt;
        logic [BYTE_BITS-1:0]   tx;
        logic [BYTE_BITS-1:0]   rx;
        logic                   pres_seen;
        logic                   busy;
        logic                   done;
        logic                   presence;
        logic [BYTE_BITS-1:0]   rdata;
        logic                   drive;
    } regs_t;

    regs_t r_q, r_d;

    logic             line_s;
    logic [CNT_W-1:0] t_rst_low, t_pres_smp, t_rst_rel, t_slot;
    logic [CNT_W-1:0] t_w1_low, t_rd_low, t_rd_smp, t_rec;
    logic [CNT_W-1:0] low_len;
    logic             cnt_last;

    swire_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (line_in),
        .d_out (line_s)
    );

    swire_timing #(
        .CNT_W(CNT_W),
        .STD_RST_LOW(STD_RST_LOW), .STD_PRES_SMP(STD_PRES_SMP), .STD_RST_REL(STD_RST_REL),
        .STD_SLOT(STD_SLOT), .STD_W1_LOW(STD_W1_LOW), .STD_RD_LOW(STD_RD_LOW),
        .STD_RD_SMP(STD_RD_SMP), .STD_REC(STD_REC),
        .OD_RST_LOW(OD_RST_LOW), .OD_PRES_SMP(OD_PRES_SMP), .OD_RST_REL(OD_RST_REL),
        .OD_SLOT(OD_SLOT), .OD_W1_LOW(OD_W1_LOW), .OD_RD_LOW(OD_RD_LOW),
        .OD_RD_SMP(OD_RD_SMP), .OD_REC(OD_REC)
    ) u_timing (
        .od_sel     (r_q.od),
        .t_rst_low  (t_rst_low),
        .t_pres_smp (t_pres_smp),
        .t_rst_rel  (t_rst_rel),
        .t_slot     (t_slot),
        .t_w1_low   (t_w1_low),
        .t_rd_low   (t_rd_low),
        .t_rd_smp   (t_rd_smp),
        .t_rec      (t_rec)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        cnt_last = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid && (cmd_op != 2'd3)) begin
                    r_d.od   = overdrive;
                    r_d.op   = cmd_op;
                    r_d.byt  = cmd_byte;
                    r_d.tx   = cmd_wdata;
                    r_d.rx   = '0;
                    r_d.idx  = '0;
                    r_d.cnt  = '0;
                    r_d.busy = 1'b1;
                    r_d.pres_seen = 1'b0;
                    r_d.state = (cmd_op == OP_RESET) ? ST_RST_LOW : ST_SLOT;
                end
            end
            ST_RST_LOW: begin
                cnt_last = (r_q.cnt == t_rst_low - 1'b1);
                r_d.cnt  = cnt_last ? '0 : r_q.cnt + 1'b1;
                if (cnt_last) r_d.state = ST_RST_REL;
            end
            ST_RST_REL: begin
                cnt_last = (r_q.cnt == t_rst_rel - 1'b1);
                r_d.cnt  = r_q.cnt + 1'b1;
                if (r_q.cnt == t_pres_smp - 1'b1) r_d.pres_seen = ~line_s;
                if (cnt_last) begin
                    r_d.state    = ST_IDLE;
                    r_d.cnt      = '0;
                    r_d.busy     = 1'b0;
                    r_d.done     = 1'b1;
                    r_d.presence = r_q.pres_seen;
                end
            end
            ST_SLOT: begin
                cnt_last = (r_q.cnt == t_slot - 1'b1);
                r_d.cnt  = r_q.cnt + 1'b1;
                if ((r_q.op == OP_READ) && (r_q.cnt == t_rd_smp - 1'b1))
                    r_d.rx = {line_s, r_q.rx[BYTE_BITS-1:1]};
                if (cnt_last) begin
                    r_d.state = ST_REC;
                    r_d.cnt   = '0;
                    r_d.tx    = {1'b1, r_q.tx[BYTE_BITS-1:1]};
                end
            end
            ST_REC: begin
                cnt_last = (r_q.cnt == t_rec - 1'b1);
                r_d.cnt  = r_q.cnt + 1'b1;
                if (cnt_last) begin
                    r_d.cnt = '0;
                    if (r_q.byt && (r_q.idx != LAST_IDX)) begin
                        r_d.idx   = r_q.idx + 1'b1;
                        r_d.state = ST_SLOT;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.busy  = 1'b0;
                        r_d.done  = 1'b1;
                        if (r_q.op == OP_READ)
                            r_d.rdata = r_q.byt ? r_q.rx
                                                : {{(BYTE_BITS-1){1'b0}}, r_q.rx[BYTE_BITS-1]};
                    end
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.busy  = 1'b0;
            end
        endcase

        unique case (r_d.op)
            OP_WRITE: low_len = r_d.tx[0] ? t_w1_low : t_slot;
            OP_READ:  low_len = t_rd_low;
            default:  low_len = t_slot;
        endcase

        r_d.drive = (r_d.state == ST_RST_LOW) ||
                    ((r_d.state == ST_SLOT) && (r_d.cnt < low_len));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign drive_low = r_q.drive;
    assign busy      = r_q.busy;
    assign done      = r_q.done;
    assign presence  = r_q.presence;
    assign rdata     = r_q.rdata;
endmodule

// File: rtl/swire_master_chk.sv
module swire_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       busy,
    input logic       done,
    input logic       drive_low,
    input logic       presence,
    input logic [7:0] rdata
);
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !drive_low);

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (cmd_op != 2'd3)) |=> busy);

    p_bad_op_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_valid && (cmd_op != 2'd3))) |=> !busy);

    p_presence_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(presence) |-> done);

    p_rdata_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);
endmodule

bind swire_master swire_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done),
    .drive_low (drive_low),
    .presence  (presence),
    .rdata     (rdata)
);

// File: tb/tb_swire_master.sv
module tb_swire_master;
    localparam int CLK_PERIOD = 10;

    localparam int S_RL = 40, S_PS = 8, S_RR = 30, S_SL = 16, S_W1 = 2, S_RDL = 2, S_RS = 6, S_RC = 3;
    localparam int O_RL = 20, O_PS = 5, O_RR = 12, O_SL = 8,  O_W1 = 1, O_RDL = 1, O_RS = 4, O_RC = 2;
    localparam int RESET_THRESH = 18;
    localparam int SHORT_LOW    = 2;
    localparam int WATCHDOG     = 150000;

    typedef struct packed {
        logic       od;
        logic [1:0] op;
        logic       byt;
        logic [7:0] wdata;
        logic [7:0] resp;
        logic       present;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b0, 8'h00, 8'hFF, 1'b1},
        '{1'b0, 2'd0, 1'b0, 8'h00, 8'hFF, 1'b0},
        '{1'b0, 2'd1, 1'b0, 8'h01, 8'hFF, 1'b0},
        '{1'b0, 2'd1, 1'b0, 8'h00, 8'hFF, 1'b0},
        '{1'b0, 2'd2, 1'b0, 8'h00, 8'hFE, 1'b0},
        '{1'b0, 2'd2, 1'b0, 8'h00, 8'hFF, 1'b0},
        '{1'b0, 2'd1, 1'b1, 8'hA5, 8'hFF, 1'b0},
        '{1'b0, 2'd2, 1'b1, 8'h00, 8'h3C, 1'b0},
        '{1'b1, 2'd0, 1'b0, 8'h00, 8'hFF, 1'b1},
        '{1'b1, 2'd1, 1'b1, 8'h5A, 8'hFF, 1'b0},
        '{1'b1, 2'd2, 1'b1, 8'h00, 8'hC3, 1'b0},
        '{1'b1, 2'd1, 1'b0, 8'h00, 8'hFF, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic       cmd_byte = 1'b0;
    logic [7:0] cmd_wdata = 8'h00;
    logic       overdrive = 1'b0;
    logic       line_in;
    logic       drive_low, busy, done, presence;
    logic [7:0] rdata;

    logic       slave_low = 1'b0;
    int         slave_cnt = 0;
    logic [7:0] slave_resp = 8'hFF;
    logic       slave_present = 1'b0;
    int         slave_hold = S_RS;

    int         run = 0;
    int         first_run = 0;
    logic [7:0] wr_log = 8'h00;
    int         busy_cnt = 0;
    int         period = 0;
    int         last_rise = -1;
    int         cyc = 0;
    logic       prev_drive = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    assign line_in = !(drive_low || slave_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    swire_master #(
        .STD_RST_LOW(S_RL), .STD_PRES_SMP(S_PS), .STD_RST_REL(S_RR), .STD_SLOT(S_SL),
        .STD_W1_LOW(S_W1), .STD_RD_LOW(S_RDL), .STD_RD_SMP(S_RS), .STD_REC(S_RC),
        .OD_RST_LOW(O_RL), .OD_PRES_SMP(O_PS), .OD_RST_REL(O_RR), .OD_SLOT(O_SL),
        .OD_W1_LOW(O_W1), .OD_RD_LOW(O_RDL), .OD_RD_SMP(O_RS), .OD_REC(O_RC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .cmd_wdata(cmd_wdata), .overdrive(overdrive),
        .line_in(line_in), .drive_low(drive_low), .busy(busy), .done(done),
        .presence(presence), .rdata(rdata)
    );

    // Wire monitor and slave model, evaluated away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (busy) busy_cnt <= busy_cnt + 1;
        if (slave_cnt > 0) begin
            slave_cnt <= slave_cnt - 1;
            slave_low <= (slave_cnt > 1);
        end
        if (drive_low && !prev_drive) begin
            if (last_rise >= 0) period <= cyc - last_rise;
            last_rise <= cyc;
            if (!slave_resp[0]) begin
                slave_cnt <= slave_hold;
                slave_low <= 1'b1;
            end
            slave_resp <= {1'b1, slave_resp[7:1]};
        end
        if (drive_low) begin
            run <= run + 1;
        end else if (prev_drive) begin
            if (first_run == 0) first_run <= run;
            if (run <= SHORT_LOW) wr_log <= {1'b1, wr_log[7:1]};
            else if (run < RESET_THRESH) wr_log <= {1'b0, wr_log[7:1]};
            else if (slave_present) begin
                slave_cnt <= 8;
                slave_low <= 1'b1;
            end
            run <= 0;
        end
        prev_drive <= drive_low;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    task automatic wait_done(output int ok);
        ok = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        first_run = 0; wr_log = 8'h00; busy_cnt = 0; period = 0; last_rise = -1;
        slave_resp = v.resp; slave_present = v.present;
        slave_hold = v.od ? O_RS : S_RS;
        cmd_valid = 1'b1; cmd_op = v.op; cmd_byte = v.byt;
        cmd_wdata = v.wdata; overdrive = v.od;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic int exp_first_low(input vec_t v);
        if (v.op == 2'd0) return v.od ? O_RL : S_RL;
        if (v.op == 2'd1) return v.wdata[0] ? (v.od ? O_W1 : S_W1) : (v.od ? O_SL : S_SL);
        return v.od ? O_RDL : S_RDL;
    endfunction

    function automatic int exp_busy(input vec_t v);
        if (v.op == 2'd0) return v.od ? (O_RL + O_RR) : (S_RL + S_RR);
        return (v.byt ? 8 : 1) * (v.od ? (O_SL + O_RC) : (S_SL + S_RC));
    endfunction

    initial begin
        int ok;
        logic       pres_before;
        logic [7:0] rd_before;
        fork
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_fail++;
                n_checks++;
                $display("FAIL watchdog: actual timeout expected completion");
                finish_run();
            end
        join_none

        repeat (3) @(negedge clk);
        // R11: state after reset
        check("R11", "drive_low at reset", int'(drive_low), 0);
        check("R11", "busy at reset", int'(busy), 0);
        check("R11", "done at reset", int'(done), 0);
        check("R11", "presence at reset", int'(presence), 0);
        check("R11", "rdata at reset", int'(rdata), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            vec_t v;
            v = VECS[k];
            issue(v);
            // R9: busy from the cycle after accept
            check("R9", "busy after accept", int'(busy), 1);
            wait_done(ok);
            check("R12", "done reached", ok, 1);
            check("R12", "busy low with done", int'(busy), 0);
            // R1 R3 R4 R5 R10: first low pulse length per op and speed
            check(v.op == 2'd0 ? "R1" : (v.op == 2'd2 ? "R5" : (v.wdata[0] ? "R3" : "R4")),
                  v.od ? "first low (R10 overdrive)" : "first low", first_run, exp_first_low(v));
            check(v.op == 2'd0 ? "R1" : "R6", "busy cycles", busy_cnt, exp_busy(v));
            if (v.op == 2'd0)
                check("R2", "presence", int'(presence), int'(v.present));
            if (v.op == 2'd1 && v.byt)
                check("R7", "byte written LSB first", int'(wr_log), int'(v.wdata));
            if (v.op == 2'd1 && !v.byt)
                check("R3", "single written bit", int'(wr_log[7]), int'(v.wdata[0]));
            if (v.op == 2'd2 && v.byt)
                check("R8", "byte read LSB first", int'(rdata), int'(v.resp));
            if (v.op == 2'd2 && !v.byt)
                check("R5", "bit read", int'(rdata), int'({7'b0, v.resp[0]}));
            if (v.byt)
                check("R6", "slot start spacing", period, v.od ? (O_SL + O_RC) : (S_SL + S_RC));
            @(negedge clk);
            check("R12", "done one cycle", int'(done), 0);
            repeat (2) @(negedge clk);
        end

        // R9: command while busy is ignored
        pres_before = presence;
        issue('{1'b0, 2'd2, 1'b0, 8'h00, 8'hFE, 1'b0});
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_byte = 1'b1; overdrive = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(ok);
        check("R9", "busy-time command ignored: busy cycles", busy_cnt, S_SL + S_RC);
        check("R9", "busy-time command ignored: rdata", int'(rdata), 0);
        check("R9", "busy-time command ignored: presence", int'(presence), int'(pres_before));
        repeat (4) @(negedge clk);
        check("R9", "no late start", int'(busy), 0);

        // R9: op code 3 is ignored
        rd_before = rdata;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_byte = 1'b0; overdrive = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9", "op 3 busy", int'(busy), 0);
        repeat (3) @(negedge clk);
        check("R9", "op 3 drive", int'(drive_low), 0);
        check("R9", "op 3 rdata", int'(rdata), int'(rd_before));

        finish_run();
    end
endmodule